// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Front End

This block sits between five hardware interrupt lines and an 8-bit processor core. It decides which request, if any, the core takes at each instruction boundary, and it supplies the 16-bit address of the service routine.

The five lines follow mixed trigger rules:
- The non-maskable line has the highest priority. It needs a rising edge, and the line must then still be high when the core reaches a boundary.
- The edge line (restart 7.5) keeps its request in a latch.
- Two level lines (restarts 6.5 and 5.5) and an external line are sensed only by their level.

A restart of number n vectors to n×8. The half-numbered restarts therefore land at 0x24, 0x3C, 0x34 and 0x2C.

The core controls the block through several inputs:
- One byte write updates the three restart masks, clears the edge latch and sets a serial output bit.
- A read byte that is always valid shows the serial input, the pending lines, the global enable and the masks.
- Two strobes set and clear the global enable.

The core raises a boundary strobe at the end of each instruction. On the clock edge where that strobe is high, the block takes the highest request it may accept. It then raises a one-cycle accept pulse, presents the vector with a source code, and clears the global enable. The core then runs the push and jump sequence, which lies outside this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the three masks read as 1, and the global enable, edge latch and serial output read as 0. accept_o is 0, vector_o is 0x0000, src_o is 0, and the non-maskable edge detector is cleared.
- R2: A mask write whose bit3 is 1 loads the masks as follows: bit2 masks the edge line, bit1 masks level line A and bit0 masks level line B. A mask write whose bit3 is 0 leaves all masks unchanged.
- R3: A mask write with bit4 set clears the edge latch. If a rising edge on the edge line arrives on the same clock, the latch is set. Bit5 of the byte has no effect.
- R4: A mask write with bit6 set loads bit7 into ser_out_o. With bit6 clear, ser_out_o holds its value. Writing 0xCB masks level lines A and B, leaves the edge line unmasked and drives ser_out_o to 1.
- R5: mask_rd_o packs its fields as follows:
  - bit7: the serial input, sampled one clock earlier.
  - bit6: the edge latch.
  - bit5: the present level of line A.
  - bit4: the present level of line B.
  - bit3: the global enable.
  - bits2..0: the masks, with the edge line in bit2, line A in bit1 and line B in bit0.
- R6: The non-maskable line is accepted only when a rising edge was registered and the line is still high at the boundary. Masks and the global enable do not affect it. A high pulse that ends before the boundary is lost. After acceptance, a line that stays high is not taken again until it falls and rises.
- R7: A rising edge on the edge line sets a latch that stays set after the pin falls. Accepting the edge line clears the latch.
- R8: Level lines A and B and the external line request only while they are high at the boundary.
- R9: The fixed priority is non-maskable, then edge line, then line A, then line B, then external. The maskable sources are accepted only when the global enable is 1 and, for the three restart lines, only when their mask bit is 0. The external line has no mask bit.
- R10: Vectors are restart number × 8:
  - Non-maskable: 0x0024, src 1.
  - Edge line: 0x003C, src 2.
  - Line A: 0x0034, src 3.
  - Line B: 0x002C, src 4.
  - External line: vector 0x0000, src 5. The core fetches the external line's vector elsewhere.
- R11: Requests are evaluated only on a clock edge where boundary_i is 1. accept_o is then 1 for exactly the following cycle. vector_o and src_o hold their values until the next acceptance.
- R12: ei_i sets the global enable and di_i clears it. Any acceptance clears it, even when ei_i is high on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable line, edge then level qualified |
| edge_irq_i | input | 1 | Edge-latched restart 7.5 line |
| lvl_a_i | input | 1 | Level restart 6.5 line |
| lvl_b_i | input | 1 | Level restart 5.5 line |
| ext_irq_i | input | 1 | External level interrupt line |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Mask byte write strobe |
| mask_wdata_i | input | 8 | Mask byte |
| ser_in_i | input | 1 | Serial data input |
| mask_rd_o | output | 8 | Status byte |
| ser_out_o | output | 1 | Serial data output latch |
| accept_o | output | 1 | One-cycle acceptance pulse |
| vector_o | output | 16 | Service routine address |
| src_o | output | 3 | Accepted source code |

## Verification
The main check is a sweep over every combination of the following, each followed by one boundary strobe:
- the eight mask settings;
- the global enable on and off;
- the edge latch set and clear;
- the eight patterns of the three level lines.

Each result is compared against a priority model computed in the bench. The sweep separates a wrong priority order, a mask bit on the wrong line, and a source that leaks through while the enable is off.

Separate directed sequences cover further cases:
- A long and a short non-maskable pulse, which show that the edge and the level are both needed.
- A held non-maskable line, which must not be taken twice.
- An edge pulse that falls before the strobe, which shows that the latch holds the request.
- Mask bytes with the update bits clear, the 0xCB byte and the lone bit5, which test the field decoding.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_EDGE = 3'd2,
    SRC_LVLA = 3'd3,
    SRC_LVLB = 3'd4,
    SRC_EXT  = 3'd5
  } irq_src_e;

  // Restart numbers doubled, so that the half-numbered restarts stay integral.
  localparam logic [4:0] HALF_NMI  = 5'd9;
  localparam logic [4:0] HALF_EDGE = 5'd15;
  localparam logic [4:0] HALF_LVLA = 5'd13;
  localparam logic [4:0] HALF_LVLB = 5'd11;

  // Restart n vectors to n*8, which equals (2n)*4.
  function automatic logic [15:0] restart_addr(input logic [4:0] twice_n);
    return {9'd0, twice_n, 2'b00};
  endfunction

  function automatic logic [15:0] src_addr(input irq_src_e s);
    case (s)
      SRC_NMI:  return restart_addr(HALF_NMI);
      SRC_EDGE: return restart_addr(HALF_EDGE);
      SRC_LVLA: return restart_addr(HALF_LVLA);
      SRC_LVLB: return restart_addr(HALF_LVLB);
      default:  return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_cap.sv
// Rising-edge capture. With HOLD_LEVEL=1, the capture also needs the line to
// stay high: it drops when the line falls, and the request is only valid
// while the line is high.
module irq_edge_cap #(
  parameter bit HOLD_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic pend_o,
  output logic req_o
);
  logic prev_q;
  logic pend_q;
  logic rise_w;
  logic keep_w;

  assign rise_w = pin_i & ~prev_q;

  generate
    if (HOLD_LEVEL) begin : g_qual
      assign keep_w = pend_q & ~clr_i & pin_i;
      assign req_o  = pend_q & pin_i;
    end else begin : g_latch
      assign keep_w = pend_q & ~clr_i;
      assign req_o  = pend_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      pend_q <= rise_w | keep_w;
    end
  end

  assign pend_o = pend_q;

  AST_PEND_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(pin_i));  // R7

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int MASK_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              take_i,
  input  logic              ser_in_i,
  input  logic              p_edge_i,
  input  logic              lvl_a_i,
  input  logic              lvl_b_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              ie_o,
  output logic              ser_out_o,
  output logic              clr_edge_o,
  output logic [BYTE_W-1:0] rd_o
);
  localparam int B_MASK_EN = MASK_W;
  localparam int B_CLR     = MASK_W + 1;
  localparam int B_SER_EN  = BYTE_W - 2;
  localparam int B_SER_VAL = BYTE_W - 1;

  logic [MASK_W-1:0] mask_q;
  logic              ie_q;
  logic              sod_q;
  logic              sid_q;
  logic              mask_upd_w;
  logic              ser_upd_w;

  assign mask_upd_w = wr_i & wdata_i[B_MASK_EN];
  assign ser_upd_w  = wr_i & wdata_i[B_SER_EN];
  assign clr_edge_o = wr_i & wdata_i[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
      sod_q  <= 1'b0;
      sid_q  <= 1'b0;
    end else begin
      sid_q <= ser_in_i;
      if (mask_upd_w) mask_q <= wdata_i[MASK_W-1:0];
      if (ser_upd_w)  sod_q  <= wdata_i[B_SER_VAL];
      if (take_i)     ie_q   <= 1'b0;
      else if (di_i)  ie_q   <= 1'b0;
      else if (ei_i)  ie_q   <= 1'b1;
    end
  end

  assign mask_o    = mask_q;
  assign ie_o      = ie_q;
  assign ser_out_o = sod_q;
  assign rd_o      = {sid_q, p_edge_i, lvl_a_i, lvl_b_i, ie_q, mask_q};

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mask_upd_w) |-> $stable(mask_o));  // R2
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ser_upd_w) |-> $stable(ser_out_o));  // R4
  AST_TAKE_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !ie_o);  // R12

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_pkg::*;
#(
  parameter int VEC_W  = 16,
  parameter int N_SRC  = 5,
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              ie_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              nmi_req_i,
  input  logic              edge_req_i,
  input  logic              lvl_a_i,
  input  logic              lvl_b_i,
  input  logic              ext_i,
  output logic              take_o,
  output irq_src_e          take_src_o,
  output logic              accept_o,
  output logic [VEC_W-1:0]  vector_o,
  output irq_src_e          src_o
);
  // Candidate index 0 has the highest priority.
  logic [N_SRC-1:0] cand_w;
  logic [N_SRC-1:0] grant_w;
  irq_src_e         pick_w;
  logic             acc_q;
  logic [VEC_W-1:0] vec_q;
  irq_src_e         src_q;

  assign cand_w[0] = nmi_req_i;
  assign cand_w[1] = edge_req_i & ie_i & ~mask_i[2];
  assign cand_w[2] = lvl_a_i    & ie_i & ~mask_i[1];
  assign cand_w[3] = lvl_b_i    & ie_i & ~mask_i[0];
  assign cand_w[4] = ext_i      & ie_i;

  always_comb begin
    grant_w = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand_w[i]) grant_w = N_SRC'(1) << i;
    end
  end

  always_comb begin
    pick_w = SRC_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (grant_w[i]) pick_w = irq_src_e'(3'(i + 1));
    end
  end

  assign take_o     = boundary_i & |cand_w;
  assign take_src_o = take_o ? pick_w : SRC_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      vec_q <= '0;
      src_q <= SRC_NONE;
    end else begin
      acc_q <= take_o;
      if (take_o) begin
        vec_q <= VEC_W'(src_addr(pick_w));
        src_q <= pick_w;
      end
    end
  end

  assign accept_o = acc_q;
  assign vector_o = vec_q;
  assign src_o    = src_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));  // R9
  AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> $past(boundary_i));  // R11
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_o |-> $stable(vector_o));  // R11
  AST_MASKED_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && src_o == SRC_EDGE) |-> !$past(mask_i[2]));  // R9

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic             edge_irq_i,
  input  logic             lvl_a_i,
  input  logic             lvl_b_i,
  input  logic             ext_irq_i,
  input  logic             boundary_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             mask_wr_i,
  input  logic [7:0]       mask_wdata_i,
  input  logic             ser_in_i,
  output logic [7:0]       mask_rd_o,
  output logic             ser_out_o,
  output logic             accept_o,
  output logic [VEC_W-1:0] vector_o,
  output logic [2:0]       src_o
);
  localparam int MASK_W = 3;
  localparam int N_SRC  = 5;

  logic              take_w;
  irq_src_e          take_src_w;
  irq_src_e          src_w;
  logic              nmi_pend_w, nmi_req_w;
  logic              edge_pend_w, edge_req_w;
  logic              clr_edge_wr_w;
  logic              nmi_clr_w, edge_clr_w;
  logic [MASK_W-1:0] mask_w;
  logic              ie_w;

  assign nmi_clr_w  = take_w & (take_src_w == SRC_NMI);
  assign edge_clr_w = clr_edge_wr_w | (take_w & (take_src_w == SRC_EDGE));

  irq_edge_cap #(.HOLD_LEVEL(1'b1)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_i(nmi_i), .clr_i(nmi_clr_w),
    .pend_o(nmi_pend_w), .req_o(nmi_req_w)
  );

  irq_edge_cap #(.HOLD_LEVEL(1'b0)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(edge_irq_i), .clr_i(edge_clr_w),
    .pend_o(edge_pend_w), .req_o(edge_req_w)
  );

  irq_mask_regs #(.MASK_W(MASK_W), .BYTE_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i), .wdata_i(mask_wdata_i),
    .ei_i(ei_i), .di_i(di_i), .take_i(take_w), .ser_in_i(ser_in_i),
    .p_edge_i(edge_pend_w), .lvl_a_i(lvl_a_i), .lvl_b_i(lvl_b_i),
    .mask_o(mask_w), .ie_o(ie_w), .ser_out_o(ser_out_o),
    .clr_edge_o(clr_edge_wr_w), .rd_o(mask_rd_o)
  );

  irq_resolver #(.VEC_W(VEC_W), .N_SRC(N_SRC), .MASK_W(MASK_W)) u_res (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ie_i(ie_w),
    .mask_i(mask_w), .nmi_req_i(nmi_req_w), .edge_req_i(edge_req_w),
    .lvl_a_i(lvl_a_i), .lvl_b_i(lvl_b_i), .ext_i(ext_irq_i),
    .take_o(take_w), .take_src_o(take_src_w), .accept_o(accept_o),
    .vector_o(vector_o), .src_o(src_w)
  );

  assign src_o = src_w;

  AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);  // R11
  AST_NMI_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && src_o == 3'd1) |-> $past(nmi_i));  // R6
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && src_o == 3'd2 && !$past(edge_irq_i)) |-> !mask_rd_o[6]);  // R7
  AST_ENABLE_LOW_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> !mask_rd_o[3]);  // R12

endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 0, edg = 0, la = 0, lb = 0, ext = 0, bnd = 0, ei = 0, di = 0;
  logic wr = 0, sin = 0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic sout, acc;
  logic [15:0] vec;
  logic [2:0] src;
  int tests = 0;
  int fails = 0;
  logic [15:0] last_vec = 16'h0000;

  always #4 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .edge_irq_i(edg), .lvl_a_i(la),
    .lvl_b_i(lb), .ext_irq_i(ext), .boundary_i(bnd), .ei_i(ei), .di_i(di),
    .mask_wr_i(wr), .mask_wdata_i(wd), .ser_in_i(sin), .mask_rd_o(rd),
    .ser_out_o(sout), .accept_o(acc), .vector_o(vec), .src_o(src)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wmask(input logic [7:0] b);
    wr = 1; wd = b; tick(); wr = 0; wd = 8'h00;
  endtask

  task automatic pulse_edge();
    edg = 1; tick(); edg = 0; tick();
  endtask

  function automatic logic [15:0] rvec(input int n);
    return 16'(n * 8 + 4);
  endfunction

  // One boundary strobe; returns {accept, src, vector} as seen the next cycle.
  task automatic strobe(output logic [19:0] got);
    bnd = 1; tick(); bnd = 0;
    got = {acc, src, vec};
  endtask

  initial begin
    logic [19:0] got;
    logic [2:0]  es;
    logic [15:0] ev;
    logic        ea;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1 status byte", rd, 8'h07);
    chk("R1 serial out", sout, 0);
    chk("R1 accept/src/vec", {acc, src, vec}, 20'h0);

    // R5 serial input sampled
    sin = 1; tick();
    chk("R5 serial in bit7", rd[7], 1);
    sin = 0; tick();

    // R2 mask write with bit3 clear leaves masks
    wmask(8'h00);
    chk("R2 masks unchanged", rd[2:0], 3'b111);
    // R4 0xCB example
    wmask(8'hCB);
    chk("R4 masks after 0xCB", rd[2:0], 3'b011);
    chk("R4 ser out after 0xCB", sout, 1);
    // R4 bit6 clear holds ser out; R3 bit5 alone has no effect
    wmask(8'h20);
    chk("R3 bit5 ignored status", rd, 8'h03);
    chk("R4 ser out held", sout, 1);
    wmask(8'h40);
    chk("R4 ser out cleared", sout, 0);

    // R7 latch holds after pin falls, R3 clear via bit4
    pulse_edge();
    chk("R7 latch held", rd[6], 1);
    wmask(8'h10);
    chk("R3 latch cleared", rd[6], 0);
    // R3 rising edge wins over clear on same clock
    edg = 1; wr = 1; wd = 8'h10; tick(); wr = 0; edg = 0; tick();
    chk("R3 edge wins over clear", rd[6], 1);
    wmask(8'h10);

    // R5 level bits mirror pins
    la = 1; lb = 0; #1;
    chk("R5 line A bit5", rd[5:4], 2'b10);
    la = 0; lb = 1; #1;
    chk("R5 line B bit4", rd[5:4], 2'b01);
    lb = 0;

    // R11 no strobe means no accept
    wmask(8'h08); ei = 1; tick(); ei = 0;
    la = 1; repeat (4) tick();
    chk("R11 no accept without strobe", acc, 0);
    la = 0; di = 1; tick(); di = 0;

    // Sweep: masks x enable x edge latch x three level lines (R9, R10, R8, R7)
    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 2; e++)
        for (int l = 0; l < 2; l++)
          for (int p = 0; p < 8; p++) begin
            wmask(8'h18 | 8'(m));
            if (e != 0) begin ei = 1; tick(); ei = 0; end
            else begin di = 1; tick(); di = 0; end
            if (l != 0) pulse_edge();
            la = p[2]; lb = p[1]; ext = p[0];
            ea = 1; es = 3'd0; ev = 16'h0;
            if (e != 0 && l != 0 && !m[2]) begin es = 3'd2; ev = rvec(7); end
            else if (e != 0 && p[2] && !m[1]) begin es = 3'd3; ev = rvec(6); end
            else if (e != 0 && p[1] && !m[0]) begin es = 3'd4; ev = rvec(5); end
            else if (e != 0 && p[0]) begin es = 3'd5; ev = 16'h0000; end
            else ea = 0;
            if (!ea) ev = last_vec;
            strobe(got);
            if (ea) begin
              last_vec = ev;
            end
            chk("R9/R10 sweep accept-src-vector", got,
                {ea, (ea ? es : got[18:16]), ev});
            la = 0; lb = 0; ext = 0;
            tick();
            chk("R11 accept one cycle", acc, 0);
            if (ea) chk("R12 enable cleared", rd[3], 0);
            if (ea && es == 3'd2) chk("R7 latch cleared on accept", rd[6], 0);
          end

    // R6 non-maskable: masks all set and enable off
    wmask(8'h1F); di = 1; tick(); di = 0;
    nmi = 1; tick();
    strobe(got);
    chk("R6 nmi accepted", got, {1'b1, 3'd1, rvec(4)});
    tick();
    strobe(got);
    chk("R6 held nmi not retaken", got[19], 0);
    nmi = 0; tick(); nmi = 1; tick();
    strobe(got);
    chk("R6 nmi retaken after re-rise", got, {1'b1, 3'd1, rvec(4)});
    nmi = 0; tick();
    // short pulse lost
    nmi = 1; tick(); nmi = 0; tick();
    strobe(got);
    chk("R6 short pulse lost", got[19], 0);
    // R9 nmi beats edge line
    wmask(8'h08); ei = 1; tick(); ei = 0;
    pulse_edge(); nmi = 1; tick();
    strobe(got);
    chk("R9 nmi over edge line", got[18:16], 3'd1);
    nmi = 0;
    tick();
    chk("R7 latch kept while nmi taken", rd[6], 1);
    // R12 accept wins over ei on same clock
    ei = 1; tick();
    ei = 1; bnd = 1; tick(); bnd = 0; ei = 0;
    chk("R10 edge vector", {acc, src, vec}, {1'b1, 3'd2, rvec(7)});
    chk("R12 accept beats ei", rd[3], 0);
    tick();
    chk("R11 vector held", vec, rvec(7));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule